// File: doc/BRIEF.md
# Signed-Digit Radix-5 Partial Product Generator

This block forms the partial products of a parallel decimal multiplier. It takes an N-digit BCD multiplicand X and an N-digit BCD multiplier Y. Each multiplier digit d is split into an upper part u in {0,1,2} and a lower part l in {-2..2}, with d = 5·u + l. Every digit therefore yields two partial products. The upper one is 0, 5X or 10X. The lower one is 0, ±X or ±2X. The only multiples required are X, 2X, 5X and 10X, and each of them comes from shifts and per-digit recoding, with no carry chain. No transfer passes between digit positions, and no 3X or 4X is ever built. A reduction tree and a final decimal adder, which lie outside this block, consume the 2N partial products.

All partial products are W = N+1 digits wide and share one digit code, 4221. A negative lower product is delivered as the digit-wise nine's complement of its magnitude, together with a sign flag. The flag tells the downstream tree to add one at the least significant digit and to drop the 10^W overflow.

The block sits in a stream. Operands enter on a valid/ready handshake and are registered in a single output stage, which also has a valid/ready handshake. The input side accepts only when the output stage is empty or is being drained in the same cycle. While `out_ready` is low, the output holds its data unchanged. Back-pressure therefore passes straight through with one cycle of latency.

Top module: `sdr5_ppgen`

## Requirements
- R1: Each multiplier digit d is decomposed as d = 5·u + l using this table (d→u,l): 0→0,0; 1→0,1; 2→0,2; 3→1,−2; 4→1,−1; 5→1,0; 6→1,1; 7→1,2; 8→2,−2; 9→2,−1. The decomposition of one digit depends on no other digit.
- R2: The upper partial product of multiplier digit j equals 0, 5·X or 10·X for u = 0, 1, 2 respectively. It is never negative, and the 10·X product has a zero least significant digit.
- R3: The lower partial product of a digit with l ≥ 0 equals l·X and has its sign flag clear. For l = 0, every bit of it is zero.
- R4: For l < 0, the sign flag is set and the digit field is the bitwise inversion of the 4221 form of |l|·X. Its true value is therefore (field value) + 1 − 10^W.
- R5: Each partial product is W = N+1 digits. Digit i occupies bits [4i+3:4i], coded in 4221 with weights 4,2,2,1 from the MSB down. Row j (multiplier digit j, where digit j of `y_bcd` is bits [4j+3:4j]) occupies bits [j·4W +: 4W] of `pp_hi` and `pp_lo`, and its sign is `pp_lo_neg[j]`.
- R6: For all BCD operands, the sum over j of (upper_j + lower_j)·10^j, taking negative rows at their true value, equals X·Y.
- R7: An input transfers on a clock edge where `in_valid` and `in_ready` are both high. Its partial products appear with `out_valid` high after that edge. `in_ready` is high exactly when the output stage is empty or `out_ready` is high. Results leave in the order of acceptance, one for each accepted input.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the three data outputs keep their values.
- R9: During and right after synchronous active-low reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Block can take an operand pair |
| x_bcd | input | 4·N | Multiplicand, BCD, digit i at [4i+3:4i] |
| y_bcd | input | 4·N | Multiplier, BCD, digit j at [4j+3:4j] |
| out_valid | output | 1 | Partial products valid |
| out_ready | input | 1 | Consumer takes the partial products |
| pp_hi | output | N·4·(N+1) | Upper partial products, 4221, row j at [j·4W +: 4W] |
| pp_lo | output | N·4·(N+1) | Lower partial products, 4221, complemented when negative |
| pp_lo_neg | output | N | Sign flag of each lower partial product |

## Verification
On every cycle, assertions check three things. First, each digit split rebuilds its own digit, and a sign is raised only with a nonzero magnitude. Second, a ten-times selection shows a zero low digit. Third, the output stage keeps its data under back-pressure and gives up valid only on a handshake. The exact value of each row and the full identity that the weighted sum of all rows equals X·Y are shown only by the bench's scenarios. Those scenarios cover all-zero, all-nine, every-digit and random operands, under both continuous and random back-pressure.

// File: rtl/sdr5_pkg.sv
package sdr5_pkg;

  typedef enum logic [1:0] {
    HI_ZERO = 2'd0,
    HI_FIVE = 2'd1,
    HI_TEN  = 2'd2
  } hi_sel_e;

  // BCD digit to 4221 (weights 4,2,2,1)
  function automatic logic [3:0] bcd_to_c4221(input logic [3:0] d);
    logic [3:0] r;
    case (d)
      4'd0: r = 4'b0000;
      4'd1: r = 4'b0001;
      4'd2: r = 4'b0010;
      4'd3: r = 4'b0011;
      4'd4: r = 4'b1000;
      4'd5: r = 4'b1001;
      4'd6: r = 4'b1010;
      4'd7: r = 4'b1011;
      4'd8: r = 4'b1110;
      default: r = 4'b1111;
    endcase
    return r;
  endfunction

  // BCD digit to 5211 (weights 5,2,1,1)
  function automatic logic [3:0] bcd_to_c5211(input logic [3:0] d);
    logic [3:0] r;
    case (d)
      4'd0: r = 4'b0000;
      4'd1: r = 4'b0001;
      4'd2: r = 4'b0100;
      4'd3: r = 4'b0101;
      4'd4: r = 4'b0111;
      4'd5: r = 4'b1000;
      4'd6: r = 4'b1001;
      4'd7: r = 4'b1100;
      4'd8: r = 4'b1101;
      default: r = 4'b1111;
    endcase
    return r;
  endfunction

  // Any 5211 digit back to the 4221 form of its value
  function automatic logic [3:0] c5211_to_c4221(input logic [3:0] c);
    logic [3:0] v;
    v = (c[3] ? 4'd5 : 4'd0) + (c[2] ? 4'd2 : 4'd0)
      + {3'b000, c[1]} + {3'b000, c[0]};
    return bcd_to_c4221(v);
  endfunction

endpackage

// File: rtl/sdr5_easy_multiples.sv
module sdr5_easy_multiples
  import sdr5_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [4*N-1:0]     x_bcd,
  output logic [4*(N+1)-1:0] m1,
  output logic [4*(N+1)-1:0] m2,
  output logic [4*(N+1)-1:0] m5,
  output logic [4*(N+1)-1:0] m10
);
  localparam int W = N + 1;

  logic [4*N-1:0] x4221;
  logic [4*N-1:0] x5211;
  logic [4*W-1:0] m5_raw;  // 5211-coded digits after the x5 shift

  for (genvar i = 0; i < N; i++) begin : g_digit_code
    assign x4221[4*i +: 4] = bcd_to_c4221(x_bcd[4*i +: 4]);
    assign x5211[4*i +: 4] = bcd_to_c5211(x_bcd[4*i +: 4]);
  end

  // 1X: plain recode, zero top digit
  assign m1  = {4'b0000, x4221};
  // 2X: 5211 shifted left one bit lands in 4221, no carries
  assign m2  = {3'b000, x5211, 1'b0};
  // 10X: one whole digit to the left
  assign m10 = {x4221, 4'b0000};
  // 5X: 4221 shifted left three bits lands in 5211
  assign m5_raw = {1'b0, x4221, 3'b000};

  for (genvar i = 0; i < W; i++) begin : g_five_recode
    assign m5[4*i +: 4] = c5211_to_c4221(m5_raw[4*i +: 4]);
  end

endmodule

// File: rtl/sdr5_digit_split.sv
module sdr5_digit_split
  import sdr5_pkg::*;
(
  input  logic [3:0] digit,
  output hi_sel_e    hi_sel,
  output logic [1:0] lo_mag,
  output logic       lo_neg
);

  always_comb begin
    hi_sel = HI_ZERO;
    lo_mag = 2'd0;
    lo_neg = 1'b0;
    case (digit)
      4'd0: begin hi_sel = HI_ZERO; lo_mag = 2'd0; lo_neg = 1'b0; end
      4'd1: begin hi_sel = HI_ZERO; lo_mag = 2'd1; lo_neg = 1'b0; end
      4'd2: begin hi_sel = HI_ZERO; lo_mag = 2'd2; lo_neg = 1'b0; end
      4'd3: begin hi_sel = HI_FIVE; lo_mag = 2'd2; lo_neg = 1'b1; end
      4'd4: begin hi_sel = HI_FIVE; lo_mag = 2'd1; lo_neg = 1'b1; end
      4'd5: begin hi_sel = HI_FIVE; lo_mag = 2'd0; lo_neg = 1'b0; end
      4'd6: begin hi_sel = HI_FIVE; lo_mag = 2'd1; lo_neg = 1'b0; end
      4'd7: begin hi_sel = HI_FIVE; lo_mag = 2'd2; lo_neg = 1'b0; end
      4'd8: begin hi_sel = HI_TEN;  lo_mag = 2'd2; lo_neg = 1'b1; end
      4'd9: begin hi_sel = HI_TEN;  lo_mag = 2'd1; lo_neg = 1'b1; end
      default: begin hi_sel = HI_ZERO; lo_mag = 2'd0; lo_neg = 1'b0; end
    endcase
  end

  // R1: the two parts rebuild the digit
  always_comb begin
    if (!$isunknown(digit) && digit <= 4'd9) begin
      a_r1_split_sum: assert ((5 * int'(hi_sel)
                               + (lo_neg ? -int'(lo_mag) : int'(lo_mag)))
                              == int'(digit))
        else $error("a_r1_split_sum: digit %0d", digit);
    end
  end

endmodule

// File: rtl/sdr5_pp_select.sv
module sdr5_pp_select
  import sdr5_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [4*(N+1)-1:0] m1,
  input  logic [4*(N+1)-1:0] m2,
  input  logic [4*(N+1)-1:0] m5,
  input  logic [4*(N+1)-1:0] m10,
  input  hi_sel_e            hi_sel,
  input  logic [1:0]         lo_mag,
  input  logic               lo_neg,
  output logic [4*(N+1)-1:0] hi_pp,
  output logic [4*(N+1)-1:0] lo_pp,
  output logic               neg
);
  localparam int W = N + 1;

  logic [4*W-1:0] lo_abs;

  always_comb begin
    case (hi_sel)
      HI_FIVE: hi_pp = m5;
      HI_TEN:  hi_pp = m10;
      default: hi_pp = '0;
    endcase
  end

  always_comb begin
    case (lo_mag)
      2'd1:    lo_abs = m1;
      2'd2:    lo_abs = m2;
      default: lo_abs = '0;
    endcase
  end

  // Nine's complement per digit; the +1 is left to the tree via neg
  assign lo_pp = lo_neg ? ~lo_abs : lo_abs;
  assign neg   = lo_neg;

  always_comb begin
    // R4: a sign only ever comes with a nonzero magnitude
    if (!$isunknown(lo_neg) && !$isunknown(lo_mag)) begin
      a_r4_neg_nonzero: assert (!lo_neg || lo_mag != 2'd0)
        else $error("a_r4_neg_nonzero");
    end
    // R2: the ten-times row carries a zero low digit
    if (!$isunknown(hi_sel) && !$isunknown(hi_pp)) begin
      a_r2_ten_low_zero: assert (hi_sel != HI_TEN || hi_pp[3:0] == 4'b0000)
        else $error("a_r2_ten_low_zero");
    end
  end

endmodule

// File: rtl/sdr5_ppgen.sv
module sdr5_ppgen
  import sdr5_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [4*N-1:0]         x_bcd,
  input  logic [4*N-1:0]         y_bcd,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [N*4*(N+1)-1:0]   pp_hi,
  output logic [N*4*(N+1)-1:0]   pp_lo,
  output logic [N-1:0]           pp_lo_neg
);
  localparam int W  = N + 1;
  localparam int RW = 4 * W;

  logic [RW-1:0] m1, m2, m5, m10;
  logic [N*RW-1:0] hi_d, lo_d;
  logic [N-1:0]    neg_d;

  logic            valid_q;
  logic [N*RW-1:0] hi_q, lo_q;
  logic [N-1:0]    neg_q;

  sdr5_easy_multiples #(.N(N)) u_mult (
    .x_bcd (x_bcd),
    .m1    (m1),
    .m2    (m2),
    .m5    (m5),
    .m10   (m10)
  );

  for (genvar j = 0; j < N; j++) begin : g_row
    hi_sel_e    hsel;
    logic [1:0] lmag;
    logic       lneg;

    sdr5_digit_split u_split (
      .digit  (y_bcd[4*j +: 4]),
      .hi_sel (hsel),
      .lo_mag (lmag),
      .lo_neg (lneg)
    );

    sdr5_pp_select #(.N(N)) u_sel (
      .m1     (m1),
      .m2     (m2),
      .m5     (m5),
      .m10    (m10),
      .hi_sel (hsel),
      .lo_mag (lmag),
      .lo_neg (lneg),
      .hi_pp  (hi_d[j*RW +: RW]),
      .lo_pp  (lo_d[j*RW +: RW]),
      .neg    (neg_d[j])
    );
  end

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (in_ready) begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      neg_q <= neg_d;
    end
  end

  assign out_valid = valid_q;
  assign pp_hi     = hi_q;
  assign pp_lo     = lo_q;
  assign pp_lo_neg = neg_q;

  // R8: stalled output keeps valid and data
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(pp_hi)
                                && $stable(pp_lo) && $stable(pp_lo_neg))
    else $error("a_r8_hold_stable");

  // R7: valid is only given up after a handshake
  a_r7_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready))
    else $error("a_r7_drop_after_take");

  // R7: a full, stalled stage refuses input
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready)
    else $error("a_r7_full_blocks");

endmodule

// File: tb/sdr5_ppgen_bench.sv
module sdr5_ppgen_bench;
  localparam int N  = 8;
  localparam int W  = N + 1;
  localparam int RW = 4 * W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [4*N-1:0]     x_bcd = '0;
  logic [4*N-1:0]     y_bcd = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [N*RW-1:0]    pp_hi;
  logic [N*RW-1:0]    pp_lo;
  logic [N-1:0]       pp_lo_neg;

  int checks = 0;
  int failures = 0;
  int sent = 0;
  int recv = 0;
  int bp_mode = 0;
  bit done = 1'b0;

  logic [8*N-1:0] exp_q [$];

  always #2 clk = ~clk;  // 250 MHz

  sdr5_ppgen #(.N(N)) u_sdr5_ppgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .x_bcd     (x_bcd),
    .y_bcd     (y_bcd),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .pp_hi     (pp_hi),
    .pp_lo     (pp_lo),
    .pp_lo_neg (pp_lo_neg)
  );

  function automatic longint pow10(input int e);
    longint p = 1;
    for (int i = 0; i < e; i++) p = p * 10;
    return p;
  endfunction

  function automatic longint bcd_val(input logic [4*N-1:0] v);
    longint a = 0;
    for (int i = N - 1; i >= 0; i--) a = a * 10 + longint'(v[4*i +: 4]);
    return a;
  endfunction

  // R5: 4221 digits, weights 4,2,2,1
  function automatic longint c4221_val(input logic [RW-1:0] v);
    longint a = 0;
    for (int i = W - 1; i >= 0; i--)
      a = a * 10 + 4 * longint'(v[4*i+3]) + 2 * longint'(v[4*i+2])
                 + 2 * longint'(v[4*i+1]) + longint'(v[4*i]);
    return a;
  endfunction

  // R1 table, written from the requirement
  function automatic int upper_of(input int d);
    if (d <= 2) return 0;
    if (d <= 7) return 1;
    return 2;
  endfunction

  function automatic int lower_of(input int d);
    return d - 5 * upper_of(d);
  endfunction

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [4*N-1:0] xb, input logic [4*N-1:0] yb);
    in_valid = 1'b1;
    x_bcd    = xb;
    y_bcd    = yb;
    while (!in_ready) @(negedge clk);
    exp_q.push_back({xb, yb});
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [4*N-1:0] rnd_bcd();
    logic [4*N-1:0] v;
    for (int i = 0; i < N; i++) v[4*i +: 4] = 4'($urandom_range(9));
    return v;
  endfunction

  // consumer ready, changed just after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (bp_mode == 0) out_ready = 1'b1;
      else              out_ready = ($urandom_range(1) == 1);
    end
  end

  // monitor / scoreboard
  logic            hold_pend = 1'b0;
  logic [N*RW-1:0] snap_hi, snap_lo;
  logic [N-1:0]    snap_neg;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hold_pend) begin
        check(out_valid && pp_hi == snap_hi && pp_lo == snap_lo
              && pp_lo_neg == snap_neg,
              "R8 stalled output held", longint'(out_valid), 1);
      end
      hold_pend = out_valid && !out_ready;
      snap_hi   = pp_hi;
      snap_lo   = pp_lo;
      snap_neg  = pp_lo_neg;

      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 output without input", 1, 0);
        end else begin
          logic [8*N-1:0] item;
          longint xv, yv, sum, hv, lv, ehv, elv;
          bit ok_hi, ok_pos, ok_neg;
          longint bad_a_hi, bad_e_hi, bad_a_lo, bad_e_lo, bad_a_ng, bad_e_ng;
          item = exp_q.pop_front();
          recv++;
          xv = bcd_val(item[8*N-1 -: 4*N]);
          yv = bcd_val(item[4*N-1:0]);
          sum = 0;
          ok_hi = 1; ok_pos = 1; ok_neg = 1;
          bad_a_hi = 0; bad_e_hi = 0; bad_a_lo = 0; bad_e_lo = 0;
          bad_a_ng = 0; bad_e_ng = 0;
          for (int j = 0; j < N; j++) begin
            int d, u, l;
            logic [RW-1:0] hrow, lrow;
            d = int'(item[4*j +: 4]);
            u = upper_of(d);
            l = lower_of(d);
            hrow = pp_hi[j*RW +: RW];
            lrow = pp_lo[j*RW +: RW];
            hv  = c4221_val(hrow);
            ehv = longint'(u) * 5 * xv;
            if (hv != ehv || (u == 2 && hrow[3:0] != 4'b0000)) begin
              ok_hi = 0; bad_a_hi = hv; bad_e_hi = ehv;
            end
            if (l >= 0) begin
              lv  = c4221_val(lrow);
              elv = longint'(l) * xv;
              if (lv != elv || pp_lo_neg[j] || (l == 0 && lrow != '0)) begin
                ok_pos = 0; bad_a_lo = lv; bad_e_lo = elv;
              end
            end else begin
              lv  = c4221_val(~lrow);
              elv = longint'(-l) * xv;
              if (lv != elv || !pp_lo_neg[j]) begin
                ok_neg = 0; bad_a_ng = lv; bad_e_ng = elv;
              end
              lv = c4221_val(lrow) + 1 - pow10(W);
            end
            sum = sum + (hv + lv) * pow10(j);
          end
          check(ok_hi,  "R1/R2 upper rows", bad_a_hi, bad_e_hi);
          check(ok_pos, "R1/R3 nonnegative lower rows", bad_a_lo, bad_e_lo);
          check(ok_neg, "R4 complemented lower rows", bad_a_ng, bad_e_ng);
          check(sum == xv * yv, "R5/R6 weighted sum of rows", sum, xv * yv);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", recv, sent);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4*N-1:0] all9, seq, seq_r;
    all9 = '0; seq = '0; seq_r = '0;
    for (int i = 0; i < N; i++) begin
      all9[4*i +: 4]  = 4'd9;
      seq[4*i +: 4]   = 4'((i + 1) % 10);
      seq_r[4*i +: 4] = 4'(9 - (i % 10));
    end

    repeat (3) @(negedge clk);
    // R9: state held in reset
    check(out_valid == 1'b0, "R9 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", longint'(in_ready), 1);

    // boundary operands, no back-pressure
    send('0, '0);
    send(all9, all9);
    send(all9, '0);
    send('0, all9);
    send(seq, seq_r);
    send(seq_r, all9);
    for (int d = 0; d < 10; d++) begin
      logic [4*N-1:0] yd;
      for (int i = 0; i < N; i++) yd[4*i +: 4] = 4'((d + i) % 10);
      send(all9, yd);
      send(rnd_bcd(), yd);
    end
    for (int k = 0; k < 100; k++) send(rnd_bcd(), rnd_bcd());

    // random back-pressure
    bp_mode = 1;
    for (int k = 0; k < 200; k++) begin
      send(rnd_bcd(), rnd_bcd());
      if (k % 7 == 0) repeat (2) @(negedge clk);
    end
    bp_mode = 0;
    repeat (20) @(negedge clk);

    // R7: every accepted input produced exactly one result
    check(recv == sent && exp_q.size() == 0, "R7 result count",
          longint'(recv), longint'(sent));
    check(out_valid == 1'b0, "R7 stage empty when drained",
          longint'(out_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule